// File: doc/BRIEF.md
# ECC-Aware Direct Tag Comparator

This block decides whether an incoming lookup tag corresponds to a codeword read from a protected tag store. It does not decode and correct the stored word first. Instead it encodes the incoming tag into the same systematic code and measures the Hamming distance between that fresh codeword and the stored one. The data half of the comparison needs no encoder output, so the data XORs run while the parity bits of the incoming tag are still being formed.

The differing bits are counted by a pairwise adder tree of log2 depth. A longer code only widens the tree's first levels. A threshold stage turns the count into one of three verdicts. A verdict of match means the words are identical. A verdict of fault means the stored word is the incoming tag's codeword with a few bit errors, so the tag hits and the entry needs scrubbing. A verdict of mismatch means the distance reaches the code's minimum distance, so the entry holds a different tag.

Transactions use valid/ready on both sides through a single register stage. A request is accepted when `in_valid` and `in_ready` are high at the same clock edge. `in_ready` is high whenever the output register is empty or is being drained in that cycle. When the downstream side holds `out_ready` low, the verdict stays on the output and new requests are refused.

Top module: `ecc_tag_matcher`

## Requirements
- R1: After reset, `out_valid` is 0 and `out_verdict` is 2'b00.
- R2: The codeword layout is fixed, with K the tag width. The tag occupies bits [K-1:0]. Assign each tag bit i the (i+1)-th integer, counting from 3, that is not a power of two. Hamming bit j sits at bit K+j and is the XOR of the tag bits whose assigned integer has bit j set. R is the smallest value with 2^R >= K+R+1. The top bit, N-1 with N = K+R+1, makes the total parity of the word even. A stored word equal to the encoding of the tag gives match.
- R3: A Hamming distance of 0 between the encoded tag and `in_stored` gives the verdict 2'b00 (match).
- R4: A distance from 1 to 3 gives 2'b01 (fault).
- R5: A distance of 4 or more gives 2'b10 (mismatch).
- R6: The distance counts differing bits in the tag field and the parity field alike, over all N bits.
- R7: `in_ready` equals `!out_valid || out_ready`. An accepted request shows its verdict, with `out_valid` high, at the next clock edge.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_verdict` hold their values.
- R9: When a verdict is consumed and no request is accepted in the same cycle, `out_valid` falls at that edge.
- R10: A request offered while `in_ready` is 0 is dropped and never produces a verdict.
- R11: The block also works with a tag width of 18, which gives a 24-bit codeword, and follows the same rules.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request can be accepted |
| in_tag | input | TAG_W | Incoming uncoded tag |
| in_stored | input | CODE_W | Stored codeword, tag in low bits, parity above |
| out_valid | output | 1 | Verdict valid |
| out_ready | input | 1 | Downstream takes the verdict |
| out_verdict | output | 2 | 00 match, 01 fault, 10 mismatch |

## Verification
The bench builds two copies of the block. The first uses TAG_W=4, an 8-bit code, where every single-bit and every double-bit corruption of several tags can be applied exhaustively. The second uses TAG_W=18, a 24-bit code, which exercises a five-level tree whose leaf count is padded from 24 to 32, along with a six-bit parity field. Unrelated tag pairs and deliberate three- and four-bit corruptions probe both sides of the fault/mismatch boundary. A stalled output combined with a refused request covers the handshake rules.

// File: rtl/ecc_cmp_pkg.sv
package ecc_cmp_pkg;

  typedef enum logic [1:0] {
    V_MATCH    = 2'b00,
    V_FAULT    = 2'b01,
    V_MISMATCH = 2'b10
  } verdict_e;

  // smallest number of Hamming check bits covering k data bits
  function automatic int ham_bits(input int k);
    int r;
    r = 1;
    while ((1 << r) < k + r + 1) r++;
    return r;
  endfunction

  function automatic int code_width(input int k);
    return k + ham_bits(k) + 1;
  endfunction

  // position of data bit i among non-power-of-two integers starting at 3
  function automatic int data_pos(input int i);
    int c;
    int res;
    c   = 0;
    res = 0;
    for (int p = 3; p < 256; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (c == i && res == 0) res = p;
        c++;
      end
    end
    return res;
  endfunction

  // data bits that feed check bit j
  function automatic logic [63:0] ham_mask(input int k, input int j);
    logic [63:0] m;
    m = '0;
    for (int i = 0; i < k; i++)
      if (((data_pos(i) >> j) & 1) != 0) m[i] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/ecc_parity_enc.sv
module ecc_parity_enc #(
  parameter int TAG_W = 4,
  parameter int PAR_W = ecc_cmp_pkg::ham_bits(TAG_W) + 1
) (
  input  logic [TAG_W-1:0] tag,
  output logic [PAR_W-1:0] parity
);
  localparam int HAM_W = PAR_W - 1;

  logic [HAM_W-1:0] ham;

  for (genvar j = 0; j < HAM_W; j++) begin : g_chk
    localparam logic [63:0] FULL_MASK = ecc_cmp_pkg::ham_mask(TAG_W, j);
    localparam logic [TAG_W-1:0] MASK = FULL_MASK[TAG_W-1:0];
    assign ham[j] = ^(tag & MASK);
  end

  // overall bit makes the complete word even
  assign parity = {(^tag) ^ (^ham), ham};

endmodule

// File: rtl/bfly_weight_acc.sv
module bfly_weight_acc #(
  parameter int N_BITS = 8,
  parameter int CNT_W  = $clog2(N_BITS) + 1
) (
  input  logic [N_BITS-1:0] diff,
  output logic [CNT_W-1:0]  weight
);
  localparam int LV = $clog2(N_BITS);
  localparam int P  = 1 << LV;

  // level l holds P>>l partial counts of l+1 bits each
  for (genvar l = 0; l <= LV; l++) begin : lvl
    logic [l:0] s [P >> l];
    if (l == 0) begin : g_leaf
      for (genvar i = 0; i < P; i++) begin : g_in
        if (i < N_BITS) begin : g_real
          assign s[i] = diff[i];
        end else begin : g_pad
          assign s[i] = 1'b0;
        end
      end
    end else begin : g_node
      for (genvar i = 0; i < (P >> l); i++) begin : g_pair
        assign s[i] = {1'b0, lvl[l-1].s[2*i]} + {1'b0, lvl[l-1].s[2*i+1]};
      end
    end
  end

  assign weight = lvl[LV].s[0];

endmodule

// File: rtl/cmp_verdict.sv
module cmp_verdict #(
  parameter int CNT_W = 4,
  parameter int DMIN  = 4
) (
  input  logic [CNT_W-1:0]     weight,
  output ecc_cmp_pkg::verdict_e verdict
);
  import ecc_cmp_pkg::*;

  always_comb begin
    if (weight == '0)              verdict = V_MATCH;
    else if (int'(weight) < DMIN)  verdict = V_FAULT;
    else                           verdict = V_MISMATCH;
  end

endmodule

// File: rtl/ecc_tag_matcher.sv
module ecc_tag_matcher #(
  parameter int TAG_W  = 4,
  parameter int CODE_W = ecc_cmp_pkg::code_width(TAG_W),
  parameter int DMIN   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [TAG_W-1:0]  in_tag,
  input  logic [CODE_W-1:0] in_stored,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [1:0]        out_verdict
);
  import ecc_cmp_pkg::*;

  localparam int PAR_W = CODE_W - TAG_W;
  localparam int CNT_W = $clog2(CODE_W) + 1;

  logic [PAR_W-1:0]  enc_par;
  logic [CODE_W-1:0] diff;
  logic [CNT_W-1:0]  weight;
  verdict_e          verdict_d;
  logic              accept;
  logic              vld_q;
  logic [1:0]        verd_q;

  ecc_parity_enc #(.TAG_W(TAG_W), .PAR_W(PAR_W)) u_enc (
    .tag    (in_tag),
    .parity (enc_par)
  );

  // tag field compares immediately; parity field waits on the encoder
  assign diff[TAG_W-1:0]      = in_tag ^ in_stored[TAG_W-1:0];
  assign diff[CODE_W-1:TAG_W] = enc_par ^ in_stored[CODE_W-1:TAG_W];

  bfly_weight_acc #(.N_BITS(CODE_W), .CNT_W(CNT_W)) u_acc (
    .diff   (diff),
    .weight (weight)
  );

  cmp_verdict #(.CNT_W(CNT_W), .DMIN(DMIN)) u_dec (
    .weight  (weight),
    .verdict (verdict_d)
  );

  assign in_ready = !vld_q || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      verd_q <= V_MATCH;
    end else if (accept) begin
      vld_q  <= 1'b1;
      verd_q <= verdict_d;
    end else if (out_ready) begin
      vld_q  <= 1'b0;
    end
  end

  assign out_valid   = vld_q;
  assign out_verdict = verd_q;

  // R7
  accept_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_verdict)));

  // R9
  drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> !out_valid);

  // R3
  zero_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && diff == '0) |=> (out_verdict == V_MATCH));

  // R5
  far_mismatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && int'(weight) >= DMIN) |=> (out_verdict == V_MISMATCH));

  // R6
  weight_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (int'(weight) <= CODE_W && (weight == '0) == (diff == '0)));

endmodule

// File: tb/sim_ecc_tag_matcher.sv
`timescale 1ns/1ps
module sim_ecc_tag_matcher;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  // small configuration
  logic       iv0 = 0, ir0, ov0, or0 = 1;
  logic [3:0] tag0 = '0;
  logic [7:0] st0 = '0;
  logic [1:0] vd0;

  // wide configuration
  logic        iv1 = 0, ir1, ov1, or1 = 1;
  logic [17:0] tag1 = '0;
  logic [23:0] st1 = '0;
  logic [1:0]  vd1;

  ecc_tag_matcher #(.TAG_W(4)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(iv0), .in_ready(ir0),
    .in_tag(tag0), .in_stored(st0), .out_valid(ov0), .out_ready(or0),
    .out_verdict(vd0));

  ecc_tag_matcher #(.TAG_W(18)) u1 (
    .clk(clk), .rst_n(rst_n), .in_valid(iv1), .in_ready(ir1),
    .in_tag(tag1), .in_stored(st1), .out_valid(ov1), .out_ready(or1),
    .out_verdict(vd1));

  function automatic logic [31:0] bench_enc(input logic [31:0] t, input int k);
    int r, pos;
    logic [31:0] h, w;
    r = 1;
    while ((1 << r) < k + r + 1) r++;
    pos = 2;
    h = '0;
    for (int i = 0; i < k; i++) begin
      pos++;
      while ((pos & (pos - 1)) == 0) pos++;
      if (t[i]) h = h ^ pos;
    end
    w = (t & ((32'd1 << k) - 1)) | (h << k);
    w = w | ((^w) << (k + r));
    return w;
  endfunction

  function automatic logic [1:0] expect_v(input logic [31:0] a, input logic [31:0] b);
    int d;
    d = $countones(a ^ b);
    if (d == 0) return 2'b00;
    if (d < 4)  return 2'b01;
    return 2'b10;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic xfer0(input logic [3:0] t, input logic [7:0] s, input string req);
    @(negedge clk);
    tag0 = t; st0 = s; iv0 = 1; or0 = 1;
    @(negedge clk);
    iv0 = 0;
    chk({req, " valid"}, ov0, 1);
    chk(req, vd0, expect_v(bench_enc(t, 4), s));
  endtask

  task automatic xfer1(input logic [17:0] t, input logic [23:0] s, input string req);
    @(negedge clk);
    tag1 = t; st1 = s; iv1 = 1; or1 = 1;
    @(negedge clk);
    iv1 = 0;
    chk({req, " valid"}, ov1, 1);
    chk(req, vd1, expect_v(bench_enc(t, 18), s));
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 valid", ov0, 0);
    chk("R1 verdict", vd0, 2'b00);
    chk("R1 valid wide", ov1, 0);
    chk("R1 verdict wide", vd1, 2'b00);
  endtask

  task automatic t_exact();
    for (int t = 0; t < 16; t++) begin
      xfer0(4'(t), 8'(bench_enc(t, 4)), "R2 R3 exact");
      chk("R3 code", vd0, 2'b00);
    end
  endtask

  task automatic t_single();
    for (int n = 0; n < 4; n++) begin
      logic [3:0] t = 4'($urandom);
      for (int b = 0; b < 8; b++) begin
        xfer0(t, 8'(bench_enc(t, 4)) ^ (8'd1 << b), "R4 R6 single");
        chk("R4 code", vd0, 2'b01);
      end
    end
  endtask

  task automatic t_double();
    for (int n = 0; n < 4; n++) begin
      logic [3:0] t = 4'($urandom);
      for (int a = 0; a < 8; a++)
        for (int b = a + 1; b < 8; b++)
          xfer0(t, 8'(bench_enc(t, 4)) ^ (8'd1 << a) ^ (8'd1 << b), "R4 double");
    end
  endtask

  task automatic t_unrelated();
    for (int a = 0; a < 16; a++) begin
      int b = (a + 1 + int'($urandom_range(0, 14))) % 16;
      xfer0(4'(a), 8'(bench_enc(b, 4)), "R5 unrelated");
    end
    xfer0(4'h5, 8'(bench_enc(5, 4)) ^ 8'h0F, "R5 four bits");
    chk("R5 code", vd0, 2'b10);
    xfer0(4'h5, 8'(bench_enc(5, 4)) ^ 8'h0E, "R4 three bits");
  endtask

  task automatic t_stall();
    logic [7:0] far;
    @(negedge clk);
    tag0 = 4'h9; st0 = 8'(bench_enc(9, 4)); iv0 = 1; or0 = 0;
    chk("R7 ready empty", ir0, 1);
    @(negedge clk);
    chk("R7 valid", ov0, 1);
    chk("R7 verdict", vd0, 2'b00);
    chk("R7 ready stalled", ir0, 0);
    far = 8'(bench_enc(9, 4)) ^ 8'hF0;
    st0 = far;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk("R8 held valid", ov0, 1);
      chk("R10 R8 held verdict", vd0, 2'b00);
    end
    iv0 = 0; or0 = 1;
    @(negedge clk);
    chk("R9 R10 drained", ov0, 0);
    chk("R7 ready after drain", ir0, 1);
  endtask

  task automatic t_wide();
    for (int n = 0; n < 4; n++) begin
      logic [17:0] t = 18'($urandom);
      logic [23:0] c = 24'(bench_enc(t, 18));
      xfer1(t, c, "R11 exact");
      for (int b = 0; b < 24; b++) xfer1(t, c ^ (24'd1 << b), "R11 single");
      xfer1(t, c ^ 24'h800001, "R11 double");
      xfer1(t, c ^ 24'h070000, "R11 triple");
      xfer1(t, c ^ 24'h00000F, "R11 four");
      xfer1(18'(t ^ 18'h2A5), c, "R11 unrelated");
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_reset();
    t_exact();
    t_single();
    t_double();
    t_unrelated();
    t_stall();
    t_wide();
    repeat (2) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule